// File: doc/BRIEF.md
# Double-Buffered Fetch Block Former

This block sits between an instruction cache and an instruction length decoder. It asks the cache for naturally aligned 16-byte code lines, at most one per cycle, and keeps two neighbouring lines in a pair of buffer halves. From the 32-byte window that the two halves form, it cuts a 16-byte fetch block that can start at any byte. A block whose start offset is zero needs only the lower half. Any other block spans into the upper half and waits until both halves are present.

Only one block is outstanding at a time. After the decoder takes a block, it reports how many bytes of that block hold complete instructions. The next block starts at the byte after them. If that report does not arrive within a parameterised number of cycles, the former gives up and starts the next block at the following 16-byte boundary.

A taken jump redirects the former. It flushes both halves and any pending request and restarts at the jump target. A fixed rule decides two things from the number of decode groups in the block that held the jump and from two boundary-crossing flags: how many extra cycles the output stays blank, and whether the restart is at the target byte or at the start of the target's 16-byte line. A mispredicted branch always restarts at the line start.

Top module: `fetch_block_former`

## Requirements
- R1: From reset until the first redirect, `lineReq` and `outValid` are 0.
- R2: In the cycle after a redirect, the former requests the line that holds the restart address (`lineAddr` = that address with its low 4 bits cleared). It requests the following line once the first has arrived. It holds `lineReq` at 0 while both buffer halves are full.
- R3: Byte i of `outData` (bits 8i+7..8i) is the code byte at address `outAddr`+i, for i = 0..15.
- R4: After a block is accepted, a boundary report (`bndValid`=1, `bndOff` = 1..16 bytes) makes the next block start at the accepted block's `outAddr` + `bndOff`.
- R5: If no boundary report arrives within BND_WAIT cycles of acceptance, the next block starts at the accepted block's start address with its low 4 bits cleared, plus 16. A boundary report that arrives after this fallback is ignored.
- R6: The extra blank cycles after a redirect depend on G, A and B. G is the group count: `jmpGroups` 0 or 1 means one group, 2 means two, 3 means three or more. A is `jmpCrossBlk` and B is `jmpCrossTgt`. The extra cycles are A+B for G=1, 1 only when A=B=1 for G=2, and 0 for G≥3. The first `outValid` appears 2 cycles after the redirect edge, plus 1 if the restart address is not 16-byte aligned, plus the extra cycles.
- R7: The restart address is the target with its low 4 bits cleared in two cases: G=1 with B=0, and G=2 with A=1 and B=0. In every other case it is the target itself.
- R8: When `jmpMispred`=1, the restart is at the target with its low 4 bits cleared and no extra cycles are added, whatever G, A and B are.
- R9: A redirect takes priority over every other event and flushes the buffer. `outValid` is 0 in the cycle after it.
- R10: While `outValid`=1 and `outReady`=0, `outValid` stays 1 and `outAddr` and `outData` stay stable, unless a redirect occurs.
- R11: After a block is accepted, `outValid` stays 0 until a boundary report or the fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| jmpValid | input | 1 | Redirect strobe |
| jmpTarget | input | AW | Jump target byte address |
| jmpGroups | input | 2 | Decode groups in the jump block (0/1: one, 2: two, 3: three or more) |
| jmpCrossBlk | input | 1 | The jump block crosses a 16-byte boundary |
| jmpCrossTgt | input | 1 | The first instruction at the target crosses a 16-byte boundary |
| jmpMispred | input | 1 | The redirect is a misprediction recovery |
| lineReq | output | 1 | Line request to the cache |
| lineAddr | output | AW | Aligned address of the requested line |
| lineValid | input | 1 | The cache returns the requested line this cycle |
| lineData | input | 128 | Line bytes, byte 0 in the low bits |
| outValid | output | 1 | Fetch block available |
| outReady | input | 1 | The length decoder accepts the block |
| outAddr | output | AW | Start address of the block |
| outData | output | 128 | 16 block bytes, first byte in the low bits |
| bndValid | input | 1 | Boundary report strobe |
| bndOff | input | 5 | Bytes of complete instructions in the accepted block (1..16) |

## Verification
The hardest cases to reach from the ports are those where timing alone decides the result. One is the fallback start followed by a boundary report that comes too late. Another is a stalled block held while a redirect arrives. The bench withholds the boundary report until the fallback block is on the output. It then drives a late report while `outReady` is low and confirms that the block address is unchanged. Every G/A/B combination is steered from targets at a non-zero line offset. This makes an aligned restart distinguishable from an instruction restart by both the start address and the extra cycle that a two-line window costs.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  typedef struct packed {
    logic run;        // former active, may fetch lines
    logic redirect;   // flush and restart
    logic advBnd;     // advance by reported boundary
    logic advAlign;   // advance to next aligned line (fallback)
  } fbfStrobes_t;

  // Extra blank cycles after a redirect
  function automatic logic [1:0] jumpDelay(input logic [1:0] groups,
                                           input logic crossBlk,
                                           input logic crossTgt,
                                           input logic mispred);
    logic [1:0] d;
    if (mispred) d = 2'd0;
    else begin
      case (groups)
        2'd2:    d = {1'b0, crossBlk & crossTgt};
        2'd3:    d = 2'd0;
        default: d = {1'b0, crossBlk} + {1'b0, crossTgt};
      endcase
    end
    return d;
  endfunction

  // Restart at the aligned line start instead of the target byte
  function automatic logic restartAligned(input logic [1:0] groups,
                                          input logic crossBlk,
                                          input logic crossTgt,
                                          input logic mispred);
    logic r;
    if (mispred) r = 1'b1;
    else begin
      case (groups)
        2'd2:    r = crossBlk & ~crossTgt;
        2'd3:    r = 1'b0;
        default: r = ~crossTgt;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/fbf_datapath.sv
module fbf_datapath
  import fbf_pkg::*;
#(
  parameter int AW = 16,
  parameter int LINE_BYTES = 16,
  localparam int OFFW = $clog2(LINE_BYTES),
  localparam int LW = AW - OFFW,
  localparam int DW = LINE_BYTES * 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  fbfStrobes_t     stb,
  input  logic [AW-1:0]   restartAddr,
  input  logic [OFFW:0]   bndOff,
  input  logic            lineValid,
  input  logic [DW-1:0]   lineData,
  output logic            lineReq,
  output logic [AW-1:0]   lineAddr,
  output logic            avail,
  output logic [AW-1:0]   outAddr,
  output logic [DW-1:0]   outData
);

  logic [LW-1:0]   baseLine;
  logic [OFFW-1:0] ptrOff;
  logic            v0, v1;
  logic [DW-1:0]   d0, d1;

  logic            take;
  logic            n0v, n1v;
  logic [DW-1:0]   n0d, n1d;
  logic            step;
  logic [OFFW:0]   sum;
  logic            crossLine;
  logic [OFFW-1:0] newOff;
  logic [2*DW-1:0] window;
  logic [2*DW-1:0] shifted;

  assign lineReq  = stb.run && !(v0 && v1);
  assign lineAddr = {(v0 ? baseLine + LW'(1) : baseLine), OFFW'(0)};
  assign take     = lineReq && lineValid;

  always_comb begin
    n0v = v0 | (take & ~v0);
    n0d = (take && !v0) ? lineData : d0;
    n1v = v1 | (take & v0);
    n1d = (take && v0) ? lineData : d1;
    step = stb.advBnd || stb.advAlign;
    sum  = {1'b0, ptrOff} + bndOff;
    if (stb.advAlign) begin
      crossLine = 1'b1;
      newOff    = '0;
    end else begin
      crossLine = sum[OFFW];
      newOff    = sum[OFFW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLine <= '0;
      ptrOff   <= '0;
      v0 <= 1'b0;
      v1 <= 1'b0;
      d0 <= '0;
      d1 <= '0;
    end else if (stb.redirect) begin
      baseLine <= restartAddr[AW-1:OFFW];
      ptrOff   <= restartAddr[OFFW-1:0];
      v0 <= 1'b0;
      v1 <= 1'b0;
    end else if (step && crossLine) begin
      baseLine <= baseLine + LW'(1);
      ptrOff   <= newOff;
      v0 <= n1v;
      d0 <= n1d;
      v1 <= 1'b0;
    end else begin
      if (step) ptrOff <= newOff;
      v0 <= n0v;
      d0 <= n0d;
      v1 <= n1v;
      d1 <= n1d;
    end
  end

  assign avail   = v0 && (ptrOff == '0 || v1);
  assign window  = {d1, d0};
  assign shifted = window >> {ptrOff, 3'b000};
  assign outData = shifted[DW-1:0];
  assign outAddr = {baseLine, ptrOff};

  // R2
  restart_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.redirect |=> lineReq && lineAddr == {$past(restartAddr[AW-1:OFFW]), OFFW'(0)});

  // R10
  window_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (avail && !stb.redirect && !stb.advBnd && !stb.advAlign) |=> avail);

endmodule

// File: rtl/fbf_control.sv
module fbf_control
  import fbf_pkg::*;
#(
  parameter int AW = 16,
  parameter int OFFW = 4,
  parameter int BND_WAIT = 4,
  localparam int BW = $clog2(BND_WAIT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          jmpValid,
  input  logic [AW-1:0] jmpTarget,
  input  logic [1:0]    jmpGroups,
  input  logic          jmpCrossBlk,
  input  logic          jmpCrossTgt,
  input  logic          jmpMispred,
  input  logic          bndValid,
  input  logic          avail,
  input  logic          outReady,
  output fbfStrobes_t   stb,
  output logic          outValid,
  output logic [AW-1:0] restartAddr
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} state_t;

  state_t        state;
  logic [1:0]    holdCnt;
  logic [BW-1:0] waitCnt;
  logic          accept;

  assign restartAddr = restartAligned(jmpGroups, jmpCrossBlk, jmpCrossTgt, jmpMispred)
                       ? {jmpTarget[AW-1:OFFW], OFFW'(0)} : jmpTarget;

  assign outValid = (state == S_RUN) && avail && (holdCnt == 2'd0);
  assign accept   = outValid && outReady;

  always_comb begin
    stb.run      = (state != S_IDLE);
    stb.redirect = jmpValid;
    stb.advBnd   = (state == S_WAIT) && bndValid && !jmpValid;
    stb.advAlign = (state == S_WAIT) && !bndValid && !jmpValid
                   && (waitCnt == BW'(BND_WAIT - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      holdCnt <= '0;
      waitCnt <= '0;
    end else if (jmpValid) begin
      state   <= S_RUN;
      holdCnt <= jumpDelay(jmpGroups, jmpCrossBlk, jmpCrossTgt, jmpMispred);
      waitCnt <= '0;
    end else begin
      case (state)
        S_RUN: begin
          if (avail && holdCnt != 2'd0) holdCnt <= holdCnt - 2'd1;
          if (accept) begin
            state   <= S_WAIT;
            waitCnt <= '0;
          end
        end
        S_WAIT: begin
          if (stb.advBnd || stb.advAlign) state <= S_RUN;
          else waitCnt <= waitCnt + BW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  single_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !jmpValid) |=> !outValid);

  // R9
  flush_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    jmpValid |=> !outValid);

  // R5
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |-> (waitCnt < BW'(BND_WAIT)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !outValid && !stb.run);

endmodule

// File: rtl/fetch_block_former.sv
module fetch_block_former
  import fbf_pkg::*;
#(
  parameter int AW = 16,
  parameter int LINE_BYTES = 16,
  parameter int BND_WAIT = 4,
  localparam int OFFW = $clog2(LINE_BYTES),
  localparam int DW = LINE_BYTES * 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          jmpValid,
  input  logic [AW-1:0] jmpTarget,
  input  logic [1:0]    jmpGroups,
  input  logic          jmpCrossBlk,
  input  logic          jmpCrossTgt,
  input  logic          jmpMispred,
  output logic          lineReq,
  output logic [AW-1:0] lineAddr,
  input  logic          lineValid,
  input  logic [DW-1:0] lineData,
  output logic          outValid,
  input  logic          outReady,
  output logic [AW-1:0] outAddr,
  output logic [DW-1:0] outData,
  input  logic          bndValid,
  input  logic [OFFW:0] bndOff
);

  fbfStrobes_t   stb;
  logic          avail;
  logic [AW-1:0] restartAddr;

  fbf_control #(.AW(AW), .OFFW(OFFW), .BND_WAIT(BND_WAIT)) ctrl (
    .clk(clk), .rstN(rstN),
    .jmpValid(jmpValid), .jmpTarget(jmpTarget), .jmpGroups(jmpGroups),
    .jmpCrossBlk(jmpCrossBlk), .jmpCrossTgt(jmpCrossTgt), .jmpMispred(jmpMispred),
    .bndValid(bndValid), .avail(avail), .outReady(outReady),
    .stb(stb), .outValid(outValid), .restartAddr(restartAddr)
  );

  fbf_datapath #(.AW(AW), .LINE_BYTES(LINE_BYTES)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .restartAddr(restartAddr),
    .bndOff(bndOff), .lineValid(lineValid), .lineData(lineData),
    .lineReq(lineReq), .lineAddr(lineAddr), .avail(avail),
    .outAddr(outAddr), .outData(outData)
  );

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !jmpValid) |=> outValid && $stable(outAddr) && $stable(outData));

endmodule

// File: tb/fetch_block_former_test.sv
`timescale 1ns/1ps
module fetch_block_former_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         jmpValid = 1'b0;
  logic [15:0]  jmpTarget = '0;
  logic [1:0]   jmpGroups = '0;
  logic         jmpCrossBlk = 1'b0, jmpCrossTgt = 1'b0, jmpMispred = 1'b0;
  logic         lineReq;
  logic [15:0]  lineAddr;
  logic         lineValid = 1'b0;
  logic [127:0] lineData = '0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [15:0]  outAddr;
  logic [127:0] outData;
  logic         bndValid = 1'b0;
  logic [4:0]   bndOff = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  fetch_block_former uut (
    .clk(clk), .rstN(rstN), .jmpValid(jmpValid), .jmpTarget(jmpTarget),
    .jmpGroups(jmpGroups), .jmpCrossBlk(jmpCrossBlk), .jmpCrossTgt(jmpCrossTgt),
    .jmpMispred(jmpMispred), .lineReq(lineReq), .lineAddr(lineAddr),
    .lineValid(lineValid), .lineData(lineData), .outValid(outValid),
    .outReady(outReady), .outAddr(outAddr), .outData(outData),
    .bndValid(bndValid), .bndOff(bndOff)
  );

  function automatic logic [7:0] codeByte(input logic [15:0] a);
    return 8'(a * 16'd5 + (a >> 7));
  endfunction

  function automatic logic [127:0] bytesFrom(input logic [15:0] a);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[i*8 +: 8] = codeByte(a + 16'(i));
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cache model: answers the request of the current cycle
  always @(negedge clk) begin
    lineValid = lineReq;
    lineData  = bytesFrom(lineAddr);
  end

  // scoreboard monitor
  always begin
    @(negedge clk);
    #1;
    if (outValid && outReady) begin
      if (expQ.size() == 0) check(0, "R3 unexpected block", 128'(outAddr), 0);
      else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outAddr == e, t, 128'(outAddr), 128'(e));
        check(outData == bytesFrom(e), "R3 data", outData, bytesFrom(e));
      end
    end
  end

  task automatic waitValid(output int n);
    n = 0;
    while (!outValid && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulseReady;
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic doJump(input logic [15:0] tgt, input logic [1:0] g,
                        input logic a, input logic b, input logic m);
    int d, lat, n;
    bit al;
    logic [15:0] ea;
    if (m) begin d = 0; al = 1; end
    else if (g == 2'd3) begin d = 0; al = 0; end
    else if (g == 2'd2) begin d = (a && b) ? 1 : 0; al = a && !b; end
    else begin d = int'(a) + int'(b); al = !b; end
    ea  = al ? {tgt[15:4], 4'h0} : tgt;
    lat = 2 + ((ea[3:0] != 0) ? 1 : 0) + d;
    expQ.push_back(ea);
    tagQ.push_back(m ? "R8 restart addr" : "R7 restart addr");
    outReady = 1'b0;
    jmpValid = 1'b1; jmpTarget = tgt; jmpGroups = g;
    jmpCrossBlk = a; jmpCrossTgt = b; jmpMispred = m;
    @(negedge clk);
    jmpValid = 1'b0;
    check(lineReq && lineAddr == {tgt[15:4], 4'h0}, "R2 first request", 128'(lineAddr), 128'({tgt[15:4], 4'h0}));
    begin
      int w;
      waitValid(w);
      n = w + 1;
    end
    check(n == lat, m ? "R8 latency" : "R6 latency", 128'(n), 128'(lat));
    pulseReady();
  endtask

  task automatic sendBnd(input logic [4:0] off, input logic [15:0] ea);
    int n;
    check(!outValid, "R11 blank after accept", 128'(outValid), 0);
    expQ.push_back(ea);
    tagQ.push_back("R4 boundary start");
    bndValid = 1'b1; bndOff = off;
    @(negedge clk);
    bndValid = 1'b0;
    waitValid(n);
    pulseReady();
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(!outValid && !lineReq, "R1 reset", 128'({outValid, lineReq}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!outValid && !lineReq, "R1 idle", 128'({outValid, lineReq}), 0);

    // R6 R7: every group/crossing combination
    for (int g = 1; g <= 3; g++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++)
          doJump(16'h1009 + 16'(g * 16'h400 + a * 16'h100 + b * 16'h40), 2'(g), a[0], b[0], 1'b0);
    // group code 0 behaves as one group
    doJump(16'h2003, 2'd0, 1'b1, 1'b1, 1'b0);

    // R8 mispredict
    doJump(16'h0237, 2'd1, 1'b1, 1'b1, 1'b1);

    // R4 boundary chain
    doJump(16'h0405, 2'd3, 1'b0, 1'b0, 1'b0);
    sendBnd(5'd7,  16'h040C);
    sendBnd(5'd16, 16'h041C);
    sendBnd(5'd4,  16'h0420);
    sendBnd(5'd16, 16'h0430);

    // R5 fallback, then a late report is ignored
    check(!outValid, "R11 blank before fallback", 128'(outValid), 0);
    expQ.push_back(16'h0440);
    tagQ.push_back("R5 fallback start");
    waitValid(n);
    bndValid = 1'b1; bndOff = 5'd3;
    @(negedge clk);
    bndValid = 1'b0;
    @(negedge clk);
    check(outValid && outAddr == 16'h0440, "R5 late report ignored", 128'(outAddr), 128'(16'h0440));
    pulseReady();

    // R10 R2: stalled block, both halves full
    jmpValid = 1'b1; jmpTarget = 16'h0500; jmpGroups = 2'd3;
    jmpCrossBlk = 0; jmpCrossTgt = 0; jmpMispred = 0;
    @(negedge clk);
    jmpValid = 1'b0;
    repeat (4) @(negedge clk);
    check(outValid && outAddr == 16'h0500, "R10 stalled block", 128'(outAddr), 128'(16'h0500));
    check(!lineReq, "R2 no request when full", 128'(lineReq), 0);
    repeat (3) @(negedge clk);
    check(outValid && outAddr == 16'h0500 && outData == bytesFrom(16'h0500),
          "R10 hold stable", 128'(outAddr), 128'(16'h0500));

    // R9 redirect during a stall
    expQ.push_back(16'h0606);
    tagQ.push_back("R9 restart after flush");
    jmpValid = 1'b1; jmpTarget = 16'h0606;
    @(negedge clk);
    jmpValid = 1'b0;
    check(!outValid, "R9 blank after redirect", 128'(outValid), 0);
    waitValid(n);
    pulseReady();

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3 all blocks seen", 128'(expQ.size()), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule